// File: doc/BRIEF.md
# Reservation Station Bank with Result Snooping

This block holds a small set of waiting operations for one class of floating-point execution unit. An upstream issue stage hands it an operation code, the tag under which its result will later appear, and two source operands. Each source arrives either as a finished value or as the tag of the unit still computing it. Storing producer tags in place of register numbers renames the architectural registers. Any entry with a pending source watches the single shared result bus. When the tag on that bus matches, the entry takes the data.

Every cycle the bank offers the execution unit one entry whose two sources are both present. When several entries qualify, the one issued earliest goes first, so execution follows data readiness and not program order. A dispatched entry stays reserved until its own result tag shows up on the result bus, and then it becomes free again. A full bank lowers its issue-ready output, and the issue stage must hold off.

Top module: `rs_bank`

## Requirements
- R1: `iss_ready` is high exactly when at least one entry is free. An issue request made while `iss_ready` is low is dropped and leaves no trace.
- R2: At issue, a source whose tag is 0 is stored as the value given with it. A source with a nonzero tag is stored as pending on that tag. The stored operation code, destination tag and both operand values appear on the dispatch outputs.
- R3: `dsp_valid` is high only while some entry that is not yet dispatched holds both operands as values. Such an entry is handed over on a cycle where `dsp_valid` and `dsp_ready` are both high.
- R4: When `bc_valid` is high and the 4-bit `bc_tag` equals a pending operand's tag, that operand takes the 64-bit `bc_data` on that clock edge and counts as ready from the next cycle on.
- R5: Every pending operand in every entry that matches the broadcast tag captures the same data on the same edge.
- R6: A dispatched entry becomes free on the edge where the broadcast tag equals its destination tag. A broadcast of the destination tag of an entry that has not been dispatched does not free it.
- R7: Once an operand holds a value, later broadcasts with other tags never change that value.
- R8: When more than one entry is ready, the one issued earliest is offered first, whatever slot it occupies.
- R9: If the result bus carries a source's producer tag in the same cycle that source is issued, the entry stores the broadcast data as a ready value.
- R10: Tag 0 marks a ready operand. A broadcast carrying tag 0 wakes nothing and changes no stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free entry exists |
| iss_op | input | OP_W (6) | Operation code to store |
| iss_dst_tag | input | TAG_W (4) | Tag of the result this operation will broadcast |
| iss_a_tag | input | TAG_W (4) | Producer tag of source A, 0 when ready |
| iss_a_val | input | DATA_W (64) | Value of source A when its tag is 0 |
| iss_b_tag | input | TAG_W (4) | Producer tag of source B, 0 when ready |
| iss_b_val | input | DATA_W (64) | Value of source B when its tag is 0 |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W (4) | Tag of the producing unit |
| bc_data | input | DATA_W (64) | Broadcast result data |
| dsp_valid | output | 1 | An entry is offered to the execution unit |
| dsp_ready | input | 1 | Execution unit accepts the offer |
| dsp_op | output | OP_W (6) | Operation code of offered entry |
| dsp_dst_tag | output | TAG_W (4) | Destination tag of offered entry |
| dsp_a | output | DATA_W (64) | Source A value of offered entry |
| dsp_b | output | DATA_W (64) | Source B value of offered entry |

## Verification
Operations are issued with both sources as values, with one source pending, and with two entries pending on a single tag that one broadcast then satisfies. The results show whether renaming is stored correctly, whether dispatch waits for readiness, and whether capture is simultaneous. A pattern in which a younger operation takes a lower slot than an older one separates age order from slot order. A bank filled to capacity shows whether extra issues are dropped and whether only a dispatched entry's own tag frees it. The same-cycle issue and broadcast case, unrelated broadcasts and tag-0 broadcasts show whether a value can be missed or overwritten.

// File: rtl/rs_bank_pkg.sv
package rs_bank_pkg;
   typedef enum logic [1:0] {
      RS_FREE = 2'd0,
      RS_WAIT = 2'd1,
      RS_EXEC = 2'd2
   } rs_state_e;
endpackage

// File: rtl/rs_operand.sv
module rs_operand #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic              bc_valid_i,
   input  logic [TAG_W-1:0]  bc_tag_i,
   input  logic [DATA_W-1:0] bc_data_i,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] val_o
);
   logic hit_new, hit_held;

   assign hit_new  = bc_valid_i && (tag_i != '0) && (bc_tag_i == tag_i);
   assign hit_held = bc_valid_i && (tag_o != '0) && (bc_tag_i == tag_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_o <= '0;
         val_o <= '0;
      end else if (load_i) begin
         if (hit_new) begin
            tag_o <= '0;
            val_o <= bc_data_i;
         end else begin
            tag_o <= tag_i;
            val_o <= val_i;
         end
      end else if (hit_held) begin
         tag_o <= '0;
         val_o <= bc_data_i;
      end
   end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
   import rs_bank_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4,
   parameter int OP_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [TAG_W-1:0]  dst_i,
   input  logic [TAG_W-1:0]  a_tag_i,
   input  logic [DATA_W-1:0] a_val_i,
   input  logic [TAG_W-1:0]  b_tag_i,
   input  logic [DATA_W-1:0] b_val_i,
   input  logic              bc_valid_i,
   input  logic [TAG_W-1:0]  bc_tag_i,
   input  logic [DATA_W-1:0] bc_data_i,
   input  logic              grant_i,
   output logic              busy_o,
   output logic              ready_o,
   output logic              exec_o,
   output logic              release_o,
   output logic [OP_W-1:0]   op_o,
   output logic [TAG_W-1:0]  dst_o,
   output logic [TAG_W-1:0]  a_tag_o,
   output logic [DATA_W-1:0] a_val_o,
   output logic [TAG_W-1:0]  b_tag_o,
   output logic [DATA_W-1:0] b_val_o
);
   rs_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RS_FREE;
         op_o    <= '0;
         dst_o   <= '0;
      end else begin
         unique case (state_q)
            RS_FREE: if (alloc_i) begin
               state_q <= RS_WAIT;
               op_o    <= op_i;
               dst_o   <= dst_i;
            end
            RS_WAIT: if (grant_i)   state_q <= RS_EXEC;
            RS_EXEC: if (release_o) state_q <= RS_FREE;
            default: state_q <= RS_FREE;
         endcase
      end
   end

   rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_a (
      .clk(clk), .rst_n(rst_n), .load_i(alloc_i),
      .tag_i(a_tag_i), .val_i(a_val_i),
      .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
      .tag_o(a_tag_o), .val_o(a_val_o)
   );

   rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_b (
      .clk(clk), .rst_n(rst_n), .load_i(alloc_i),
      .tag_i(b_tag_i), .val_i(b_val_i),
      .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
      .tag_o(b_tag_o), .val_o(b_val_o)
   );

   assign busy_o    = (state_q != RS_FREE);
   assign exec_o    = (state_q == RS_EXEC);
   assign ready_o   = (state_q == RS_WAIT) && (a_tag_o == '0) && (b_tag_o == '0);
   assign release_o = exec_o && bc_valid_i && (bc_tag_i == dst_o);
endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
   parameter int N = 3
) (
   input  logic [N-1:0] busy_i,
   output logic         any_o,
   output logic [N-1:0] pick_o
);
   always_comb begin
      pick_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy_i[i]) pick_o = N'(1) << i;
      end
   end
   assign any_o = ~&busy_i;
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
   parameter int N      = 3,
   parameter int RANK_W = 2
) (
   input  logic [N-1:0]             req_i,
   input  logic [N-1:0][RANK_W-1:0] rank_i,
   output logic [N-1:0]             pick_o
);
   logic              found;
   logic [RANK_W-1:0] best;

   always_comb begin
      pick_o = '0;
      found  = 1'b0;
      best   = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && (!found || rank_i[i] < best)) begin
            found  = 1'b1;
            best   = rank_i[i];
            pick_o = N'(1) << i;
         end
      end
   end
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
   parameter int ENTRIES = 3,
   parameter int DATA_W  = 64,
   parameter int TAG_W   = 4,
   parameter int OP_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_dst_tag,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic [TAG_W-1:0]  iss_b_tag,
   input  logic [DATA_W-1:0] iss_b_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              dsp_valid,
   input  logic              dsp_ready,
   output logic [OP_W-1:0]   dsp_op,
   output logic [TAG_W-1:0]  dsp_dst_tag,
   output logic [DATA_W-1:0] dsp_a,
   output logic [DATA_W-1:0] dsp_b
);
   localparam int RANK_W = $clog2(ENTRIES + 1);

   if (ENTRIES < 2)  begin : g_bad_entries $error("rs_bank: ENTRIES must be at least 2"); end
   if (TAG_W < 2)    begin : g_bad_tag     $error("rs_bank: TAG_W must be at least 2"); end
   if (DATA_W < 1)   begin : g_bad_data    $error("rs_bank: DATA_W must be positive"); end
   if (OP_W < 1)     begin : g_bad_op      $error("rs_bank: OP_W must be positive"); end

   logic [ENTRIES-1:0]              busy_vec, ready_vec, exec_vec, rel_vec;
   logic [ENTRIES-1:0]              free_pick, alloc_vec, oldest_vec, grant_vec;
   logic [ENTRIES-1:0][OP_W-1:0]    op_w;
   logic [ENTRIES-1:0][TAG_W-1:0]   dst_w, a_tag_w, b_tag_w;
   logic [ENTRIES-1:0][DATA_W-1:0]  a_val_w, b_val_w;
   logic [ENTRIES-1:0][RANK_W-1:0]  rank_q, rank_d, dec_w;
   logic [RANK_W-1:0]               n_busy, n_rel;
   logic                            any_free;

   rs_free_pick #(.N(ENTRIES)) u_free_pick (
      .busy_i(busy_vec), .any_o(any_free), .pick_o(free_pick)
   );

   assign iss_ready = any_free;
   assign alloc_vec = (iss_valid && any_free) ? free_pick : '0;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_entry (
         .clk(clk), .rst_n(rst_n),
         .alloc_i(alloc_vec[g]),
         .op_i(iss_op), .dst_i(iss_dst_tag),
         .a_tag_i(iss_a_tag), .a_val_i(iss_a_val),
         .b_tag_i(iss_b_tag), .b_val_i(iss_b_val),
         .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_data_i(bc_data),
         .grant_i(grant_vec[g]),
         .busy_o(busy_vec[g]), .ready_o(ready_vec[g]),
         .exec_o(exec_vec[g]), .release_o(rel_vec[g]),
         .op_o(op_w[g]), .dst_o(dst_w[g]),
         .a_tag_o(a_tag_w[g]), .a_val_o(a_val_w[g]),
         .b_tag_o(b_tag_w[g]), .b_val_o(b_val_w[g])
      );
   end

   // Issue-order rank: 0 is the oldest occupied entry.
   always_comb begin
      n_busy = '0;
      n_rel  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (busy_vec[i]) n_busy = n_busy + RANK_W'(1);
         if (rel_vec[i])  n_rel  = n_rel  + RANK_W'(1);
      end
      for (int i = 0; i < ENTRIES; i++) begin
         dec_w[i] = '0;
         for (int j = 0; j < ENTRIES; j++) begin
            if (rel_vec[j] && (rank_q[j] < rank_q[i])) dec_w[i] = dec_w[i] + RANK_W'(1);
         end
         rank_d[i] = alloc_vec[i] ? (n_busy - n_rel) : (rank_q[i] - dec_w[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rank_q <= '0;
      else        rank_q <= rank_d;
   end

   rs_oldest_pick #(.N(ENTRIES), .RANK_W(RANK_W)) u_oldest_pick (
      .req_i(ready_vec), .rank_i(rank_q), .pick_o(oldest_vec)
   );

   assign dsp_valid = |ready_vec;
   assign grant_vec = dsp_ready ? oldest_vec : '0;

   always_comb begin
      dsp_op      = '0;
      dsp_dst_tag = '0;
      dsp_a       = '0;
      dsp_b       = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (oldest_vec[i]) begin
            dsp_op      = dsp_op      | op_w[i];
            dsp_dst_tag = dsp_dst_tag | dst_w[i];
            dsp_a       = dsp_a       | a_val_w[i];
            dsp_b       = dsp_b       | b_val_w[i];
         end
      end
   end
endmodule

// File: rtl/rs_bank_checker.sv
module rs_bank_checker #(
   parameter int ENTRIES = 3,
   parameter int DATA_W  = 64,
   parameter int TAG_W   = 4,
   parameter int RANK_W  = 2
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             iss_valid,
   input logic                             iss_ready,
   input logic                             bc_valid,
   input logic [TAG_W-1:0]                 bc_tag,
   input logic [DATA_W-1:0]                bc_data,
   input logic [ENTRIES-1:0]               busy_vec,
   input logic [ENTRIES-1:0]               ready_vec,
   input logic [ENTRIES-1:0]               exec_vec,
   input logic [ENTRIES-1:0]               grant_vec,
   input logic [ENTRIES-1:0][TAG_W-1:0]    dst_w,
   input logic [ENTRIES-1:0][TAG_W-1:0]    a_tag_w,
   input logic [ENTRIES-1:0][TAG_W-1:0]    b_tag_w,
   input logic [ENTRIES-1:0][DATA_W-1:0]   a_val_w,
   input logic [ENTRIES-1:0][DATA_W-1:0]   b_val_w,
   input logic [ENTRIES-1:0][RANK_W-1:0]   rank_q
);
   a_r1_full_drops_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready) |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

   a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec));

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      a_r3_grant_has_operands: assert property (@(posedge clk) disable iff (!rst_n)
         grant_vec[i] |-> (a_tag_w[i] == '0 && b_tag_w[i] == '0 && !exec_vec[i]));

      // R4 and R5: every matching waiter captures on the same edge
      a_r4_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
         (bc_valid && bc_tag != '0 && busy_vec[i] && a_tag_w[i] == bc_tag)
         |=> (a_tag_w[i] == '0 && a_val_w[i] == $past(bc_data)));

      a_r5_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
         (bc_valid && bc_tag != '0 && busy_vec[i] && b_tag_w[i] == bc_tag)
         |=> (b_tag_w[i] == '0 && b_val_w[i] == $past(bc_data)));

      a_r6_release_on_own_tag: assert property (@(posedge clk) disable iff (!rst_n)
         (exec_vec[i] && bc_valid && bc_tag == dst_w[i]) |=> !busy_vec[i]);

      a_r6_waiting_entry_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_vec[i] && !exec_vec[i]) |=> busy_vec[i]);

      a_r7_value_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_vec[i] && !exec_vec[i] && a_tag_w[i] == '0) |=> $stable(a_val_w[i]));

      for (genvar j = 0; j < ENTRIES; j++) begin : g_pair
         if (j != i) begin : g_other
            a_r8_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
               (grant_vec[i] && ready_vec[j]) |-> (rank_q[i] < rank_q[j]));
         end
      end
   end
endmodule

bind rs_bank rs_bank_checker #(
   .ENTRIES(ENTRIES), .DATA_W(DATA_W), .TAG_W(TAG_W), .RANK_W(RANK_W)
) u_rs_bank_checker (
   .clk(clk), .rst_n(rst_n),
   .iss_valid(iss_valid), .iss_ready(iss_ready),
   .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
   .busy_vec(busy_vec), .ready_vec(ready_vec), .exec_vec(exec_vec),
   .grant_vec(grant_vec), .dst_w(dst_w),
   .a_tag_w(a_tag_w), .b_tag_w(b_tag_w),
   .a_val_w(a_val_w), .b_val_w(b_val_w),
   .rank_q(rank_q)
);

// File: tb/rs_bank_bench.sv
`timescale 1ns/1ps
module rs_bank_bench;
   localparam int ENTRIES = 3;
   localparam int DATA_W  = 64;
   localparam int TAG_W   = 4;
   localparam int OP_W    = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              iss_valid, iss_ready;
   logic [OP_W-1:0]   iss_op;
   logic [TAG_W-1:0]  iss_dst_tag, iss_a_tag, iss_b_tag;
   logic [DATA_W-1:0] iss_a_val, iss_b_val;
   logic              bc_valid;
   logic [TAG_W-1:0]  bc_tag;
   logic [DATA_W-1:0] bc_data;
   logic              dsp_valid, dsp_ready;
   logic [OP_W-1:0]   dsp_op;
   logic [TAG_W-1:0]  dsp_dst_tag;
   logic [DATA_W-1:0] dsp_a, dsp_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rs_bank #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_rs_bank (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
      .iss_dst_tag(iss_dst_tag), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
      .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
      .dsp_dst_tag(dsp_dst_tag), .dsp_a(dsp_a), .dsp_b(dsp_b)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      iss_valid = 0; iss_op = '0; iss_dst_tag = '0;
      iss_a_tag = '0; iss_a_val = '0; iss_b_tag = '0; iss_b_val = '0;
      bc_valid = 0; bc_tag = '0; bc_data = '0; dsp_ready = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      clear_inputs();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic issue(input int op, input int dst, input int at, input logic [63:0] av,
                        input int bt, input logic [63:0] bv);
      iss_valid = 1; iss_op = OP_W'(op); iss_dst_tag = TAG_W'(dst);
      iss_a_tag = TAG_W'(at); iss_a_val = av; iss_b_tag = TAG_W'(bt); iss_b_val = bv;
      @(negedge clk);
      iss_valid = 0;
   endtask

   task automatic bcast(input int tag, input logic [63:0] data);
      bc_valid = 1; bc_tag = TAG_W'(tag); bc_data = data;
      @(negedge clk);
      bc_valid = 0;
   endtask

   task automatic dispatch_one();
      dsp_ready = 1;
      @(negedge clk);
      dsp_ready = 0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 ready after reset", 64'(iss_ready), 64'd1);
      check("R3 no dispatch after reset", 64'(dsp_valid), 64'd0);
   endtask

   task automatic t_ready_values();
      do_reset();
      issue(5, 1, 0, 64'd101, 0, 64'd202);
      check("R2 valid", 64'(dsp_valid), 64'd1);
      check("R2 op", 64'(dsp_op), 64'd5);
      check("R2 dst", 64'(dsp_dst_tag), 64'd1);
      check("R2 a value", dsp_a, 64'd101);
      check("R2 b value", dsp_b, 64'd202);
   endtask

   task automatic t_shared_wakeup();
      do_reset();
      issue(1, 1, 5, 64'd0, 0, 64'd2);
      issue(2, 2, 0, 64'd3, 5, 64'd0);
      check("R3 pending blocks dispatch", 64'(dsp_valid), 64'd0);
      bcast(5, 64'd77);
      check("R4 woken", 64'(dsp_valid), 64'd1);
      check("R8 older first", 64'(dsp_dst_tag), 64'd1);
      check("R4 captured a", dsp_a, 64'd77);
      check("R2 kept b", dsp_b, 64'd2);
      dispatch_one();
      check("R5 second valid", 64'(dsp_valid), 64'd1);
      check("R5 second dst", 64'(dsp_dst_tag), 64'd2);
      check("R5 second captured b", dsp_b, 64'd77);
      check("R5 second a", dsp_a, 64'd3);
   endtask

   task automatic t_age_order();
      do_reset();
      issue(1, 1, 0, 64'd10, 0, 64'd11);
      issue(2, 2, 6, 64'd0, 0, 64'd12);
      dispatch_one();
      bcast(1, 64'd0);
      issue(3, 3, 6, 64'd0, 0, 64'd13);
      check("R3 both pending", 64'(dsp_valid), 64'd0);
      bcast(6, 64'd66);
      check("R8 oldest in higher slot", 64'(dsp_dst_tag), 64'd2);
      dispatch_one();
      check("R8 younger next", 64'(dsp_dst_tag), 64'd3);
      check("R8 younger a", dsp_a, 64'd66);
   endtask

   task automatic t_full();
      do_reset();
      issue(1, 1, 9, 64'd0, 0, 64'd1);
      issue(1, 2, 9, 64'd0, 0, 64'd1);
      issue(1, 3, 9, 64'd0, 0, 64'd1);
      check("R1 full", 64'(iss_ready), 64'd0);
      issue(7, 14, 0, 64'd5, 0, 64'd6);
      check("R1 dropped issue not dispatchable", 64'(dsp_valid), 64'd0);
      bcast(9, 64'd90);
      for (int k = 1; k <= 3; k++) begin
         check("R1 drain valid", 64'(dsp_valid), 64'd1);
         check("R8 drain order", 64'(dsp_dst_tag), 64'(k));
         dispatch_one();
      end
      check("R1 dropped issue absent", 64'(dsp_valid), 64'd0);
   endtask

   task automatic t_release();
      do_reset();
      issue(1, 3, 0, 64'd1, 0, 64'd1);
      issue(1, 4, 0, 64'd1, 0, 64'd1);
      issue(1, 5, 0, 64'd1, 0, 64'd1);
      check("R1 full before release", 64'(iss_ready), 64'd0);
      dispatch_one();
      check("R6 dispatched still held", 64'(iss_ready), 64'd0);
      bcast(4, 64'd44);
      check("R6 waiting entry not freed", 64'(iss_ready), 64'd0);
      check("R6 waiting entry still offered", 64'(dsp_dst_tag), 64'd4);
      bcast(3, 64'd33);
      check("R6 freed by own tag", 64'(iss_ready), 64'd1);
   endtask

   task automatic t_bypass();
      do_reset();
      iss_valid = 1; iss_op = 6'd9; iss_dst_tag = 4'd2;
      iss_a_tag = 4'd8; iss_a_val = 64'd0; iss_b_tag = 4'd0; iss_b_val = 64'd21;
      bc_valid = 1; bc_tag = 4'd8; bc_data = 64'd55;
      @(negedge clk);
      iss_valid = 0; bc_valid = 0;
      check("R9 ready at once", 64'(dsp_valid), 64'd1);
      check("R9 captured value", dsp_a, 64'd55);
   endtask

   task automatic t_keep_values();
      do_reset();
      issue(4, 2, 0, 64'd11, 7, 64'd0);
      bcast(0, 64'd999);
      check("R10 tag 0 wakes nothing", 64'(dsp_valid), 64'd0);
      bcast(3, 64'd500);
      bcast(7, 64'd70);
      check("R4 b woken", 64'(dsp_valid), 64'd1);
      check("R7 a kept", dsp_a, 64'd11);
      check("R4 b value", dsp_b, 64'd70);
      bcast(0, 64'd999);
      bcast(5, 64'd888);
      check("R10 a untouched", dsp_a, 64'd11);
      check("R7 b untouched", dsp_b, 64'd70);
   endtask

   initial begin
      clear_inputs();
      rst_n = 0;
      t_reset();
      t_ready_values();
      t_shared_wakeup();
      t_age_order();
      t_full();
      t_release();
      t_bypass();
      t_keep_values();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule